// File: doc/BRIEF.md
# Encoder Position Registration Latch

This block records the count of one of two encoder position counters at the instant a qualified external event occurs. The event comes from two digital strobe inputs and the primary encoder's index (Z) pulse. These can be used alone or with a strobe gated by the index. The counters and the direction flags are produced elsewhere in the same clock domain and enter as plain inputs. The strobes and the index are asynchronous, so each one passes through a synchronizer. The two strobes then pass through a stable-time noise filter. The index pulse is not filtered.

A 12-bit configuration word chooses the following:
- the encoder whose count is stored;
- the trigger source;
- the trigger edge;
- the rotation directions that allow a capture;
- the filter time.

A control write arms the latch or disarms it. Once armed, the latch takes one snapshot on the first qualifying event, raises a done flag and disarms itself. Software re-arms it to take another capture.

Top module: `pos_capture_latch`

## Requirements
- R1: While reset is high and after its release, the captured value is 0 and the done flag is 0.
- R2: Configuration bit 0 picks the stored counter: 0 stores `enc0_pos` and 1 stores `enc1_pos`. The value stored is the chosen counter as it stands in the cycle the event is recognised.
- R3: Configuration bits [2:1] pick the trigger signal: 00 = strobe 2 AND index, 01 = strobe 3, 10 = strobe 2, 11 = index alone.
- R4: Configuration bits [4:3] pick the edge: 00 = rising, 01 = falling, 10 = both, 11 = no capture at all.
- R5: Configuration bits [6:5] gate capture by the chosen encoder's direction flag (1 = forward): 00 = never, 01 = reverse only, 10 = forward only, 11 = either direction.
- R6: Configuration bits [11:8] hold N. For N > 0, a strobe's filtered level changes only after the synchronized input has held the new level for N×STEP_CYCLES clock cycles (10 by default, 100 ns at 100 MHz). Shorter pulses are dropped. N = 0 bypasses the filter.
- R7: A control write with bit 0 set (arm) arms the latch and clears the done flag. No capture happens unless the latch is armed.
- R8: A capture stores the value once, sets done, and disarms the latch. Later events leave the stored value and the done flag unchanged until the next arm.
- R9: A control write with bit 1 set (disarm) cancels a pending arm. When bits 0 and 1 are both set in one write, disarm wins.
- R10: In the AND source, edges are taken on the combined signal, which is the filtered strobe 2 ANDed with the synchronized, unfiltered index. A strobe high alone does not trigger, and an index pulse alone does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc0_pos | input | POS_W | Primary encoder position count (two's complement) |
| enc1_pos | input | POS_W | Secondary encoder position count (two's complement) |
| enc0_fwd | input | 1 | Primary encoder direction, 1 = forward |
| enc1_fwd | input | 1 | Secondary encoder direction, 1 = forward |
| enc0_index | input | 1 | Primary encoder index pulse, asynchronous |
| dig_in2 | input | 1 | Strobe input 2, asynchronous |
| dig_in3 | input | 1 | Strobe input 3, asynchronous |
| cfg_word | input | 12 | Configuration word (see R2 to R6) |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_word | input | 2 | Control bits: [0] arm, [1] disarm |
| cap_pos | output | POS_W | Captured position |
| cap_done | output | 1 | Capture-done flag |

## Verification
Some properties are checked on every clock cycle:
- an arm write clears the done flag;
- a disarm write, alone or with an arm, leaves the done flag and the value untouched;
- a stored value never moves while done is set;
- a capture only follows an armed state;
- the "off" edge setting never produces an event;
- each filter's counter stays below its limit.

Other behaviour can only be shown by the bench's scenarios:
- that the right counter and the right trigger signal are chosen;
- that direction gating uses the chosen encoder's flag;
- that pulses one filter window too short are dropped while longer ones pass;
- that the AND source needs both inputs.

// File: rtl/reglatch_pkg.sv
package reglatch_pkg;

    typedef enum logic [1:0] {
        SRC_IN2_AND_IDX = 2'b00,
        SRC_IN3         = 2'b01,
        SRC_IN2         = 2'b10,
        SRC_IDX         = 2'b11
    } trig_src_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_REV  = 2'b01,
        DIR_FWD  = 2'b10,
        DIR_ANY  = 2'b11
    } dir_mode_e;

    // Field order fixes the bit positions software writes.
    typedef struct packed {
        logic [3:0] filt_steps;  // [11:8]
        logic       spare;       // [7]
        dir_mode_e  dir;         // [6:5]
        edge_mode_e edge_m;      // [4:3]
        trig_src_e  src;         // [2:1]
        logic       enc_sel;     // [0]
    } latch_cfg_t;

    localparam int CFG_W          = $bits(latch_cfg_t);
    localparam int FILT_STEPS_MAX = 15;
    localparam int N_STROBES      = 2;

    typedef struct packed {
        logic idx;
        logic in3;
        logic in2;
    } strobe_t;

    function automatic logic dir_allows(dir_mode_e m, logic fwd);
        case (m)
            DIR_REV: return !fwd;
            DIR_FWD: return fwd;
            DIR_ANY: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic edge_fires(edge_mode_e m, logic now, logic prev);
        case (m)
            EDGE_RISE: return now && !prev;
            EDGE_FALL: return !now && prev;
            EDGE_BOTH: return now != prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rl_sync.sv
module rl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rl_stable_filter.sv
module rl_stable_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] limit,
    input  logic             din,
    output logic             dout
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             level_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (limit == '0) begin
            level_q <= din;
            cnt_q   <= '0;
        end else if (din == level_q) begin
            cnt_q   <= '0;
        end else if (cnt_q >= limit - ONE) begin
            level_q <= din;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + ONE;
        end
    end

    assign dout = (limit == '0) ? din : level_q;

    // R6: the hold counter never reaches the configured window
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (limit != '0 && $stable(limit)) |-> (cnt_q < limit));
endmodule

// File: rtl/rl_trigger.sv
module rl_trigger
    import reglatch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_src_e  src,
    input  edge_mode_e edge_m,
    input  logic       in2_f,
    input  logic       in3_f,
    input  logic       idx_s,
    output logic       evt
);
    logic sel_sig;
    logic prev_q;

    always_comb begin
        case (src)
            SRC_IN2_AND_IDX: sel_sig = in2_f & idx_s;
            SRC_IN3:         sel_sig = in3_f;
            SRC_IN2:         sel_sig = in2_f;
            default:         sel_sig = idx_s;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sel_sig;
    end

    assign evt = edge_fires(edge_m, sel_sig, prev_q);

    // R4: the disabled edge mode never yields an event
    p_edge_off_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_m == EDGE_OFF) |-> !evt);
endmodule

// File: rtl/rl_capture.sv
module rl_capture
    import reglatch_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_req,
    input  logic             disarm_req,
    input  logic             evt,
    input  logic             enc_sel,
    input  dir_mode_e        dir,
    input  logic [POS_W-1:0] enc0_pos,
    input  logic [POS_W-1:0] enc1_pos,
    input  logic             enc0_fwd,
    input  logic             enc1_fwd,
    output logic [POS_W-1:0] cap_pos,
    output logic             cap_done
);
    logic             armed_q;
    logic             fire;
    logic             sel_fwd;
    logic [POS_W-1:0] sel_pos;

    assign sel_fwd = enc_sel ? enc1_fwd : enc0_fwd;
    assign sel_pos = enc_sel ? enc1_pos : enc0_pos;
    assign fire    = armed_q && evt && dir_allows(dir, sel_fwd);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            cap_done <= 1'b0;
            cap_pos  <= '0;
        end else if (disarm_req) begin
            armed_q  <= 1'b0;
        end else if (arm_req) begin
            armed_q  <= 1'b1;
            cap_done <= 1'b0;
        end else if (fire) begin
            armed_q  <= 1'b0;
            cap_done <= 1'b1;
            cap_pos  <= sel_pos;
        end
    end

    // R7: an arm write clears the done flag
    p_arm_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (arm_req && !disarm_req) |=> !cap_done);

    // R7: done can only rise from the armed state
    p_capture_needs_arm_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_done) |-> $past(armed_q));

    // R8: a held result stays put until the next arm
    p_oneshot_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_done && !arm_req) |=> $stable(cap_pos));

    // R9: disarm (alone or with arm) blocks capture in that cycle
    p_disarm_wins_r9: assert property (@(posedge clk) disable iff (rst)
        disarm_req |=> ($stable(cap_done) && $stable(cap_pos)));
endmodule

// File: rtl/pos_capture_latch.sv
module pos_capture_latch
    import reglatch_pkg::*;
#(
    parameter int POS_W       = 32,
    parameter int STEP_CYCLES = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] enc0_pos,
    input  logic [POS_W-1:0] enc1_pos,
    input  logic             enc0_fwd,
    input  logic             enc1_fwd,
    input  logic             enc0_index,
    input  logic             dig_in2,
    input  logic             dig_in3,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_word,
    output logic [POS_W-1:0] cap_pos,
    output logic             cap_done
);
    localparam int CNT_W = $clog2(FILT_STEPS_MAX * STEP_CYCLES + 1);

    latch_cfg_t       cfg;
    strobe_t          raw;
    strobe_t          synced;
    logic [CNT_W-1:0] filt_lim;
    logic             filt_in  [N_STROBES];
    logic             filt_out [N_STROBES];
    logic             evt;

    assign cfg      = latch_cfg_t'(cfg_word);
    assign filt_lim = CNT_W'(cfg.filt_steps) * CNT_W'(STEP_CYCLES);

    assign raw.idx = enc0_index;
    assign raw.in3 = dig_in3;
    assign raw.in2 = dig_in2;

    rl_sync #(.W($bits(strobe_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign filt_in[0] = synced.in2;
    assign filt_in[1] = synced.in3;

    for (genvar i = 0; i < N_STROBES; i++) begin : g_filt
        rl_stable_filter #(.CNT_W(CNT_W)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .limit (filt_lim),
            .din   (filt_in[i]),
            .dout  (filt_out[i])
        );
    end

    rl_trigger u_trig (
        .clk    (clk),
        .rst    (rst),
        .src    (cfg.src),
        .edge_m (cfg.edge_m),
        .in2_f  (filt_out[0]),
        .in3_f  (filt_out[1]),
        .idx_s  (synced.idx),
        .evt    (evt)
    );

    rl_capture #(.POS_W(POS_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .arm_req    (ctl_wr && ctl_word[0]),
        .disarm_req (ctl_wr && ctl_word[1]),
        .evt        (evt),
        .enc_sel    (cfg.enc_sel),
        .dir        (cfg.dir),
        .enc0_pos   (enc0_pos),
        .enc1_pos   (enc1_pos),
        .enc0_fwd   (enc0_fwd),
        .enc1_fwd   (enc1_fwd),
        .cap_pos    (cap_pos),
        .cap_done   (cap_done)
    );

    // R1: outputs are cleared one cycle after reset is seen
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cap_done == 1'b0 && cap_pos == '0));
endmodule

// File: tb/pos_capture_latch_tb.sv
module pos_capture_latch_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] enc0_pos = '0;
    logic [31:0] enc1_pos = '0;
    logic        enc0_fwd = 1'b1;
    logic        enc1_fwd = 1'b1;
    logic        enc0_index = 1'b0;
    logic        dig_in2 = 1'b0;
    logic        dig_in3 = 1'b0;
    logic [11:0] cfg_word = '0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_word = '0;
    logic [31:0] cap_pos;
    logic        cap_done;

    always #5 clk = ~clk;

    pos_capture_latch u_dut (
        .clk(clk), .rst(rst),
        .enc0_pos(enc0_pos), .enc1_pos(enc1_pos),
        .enc0_fwd(enc0_fwd), .enc1_fwd(enc1_fwd),
        .enc0_index(enc0_index), .dig_in2(dig_in2), .dig_in3(dig_in3),
        .cfg_word(cfg_word), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
        .cap_pos(cap_pos), .cap_done(cap_done)
    );

    typedef struct {
        logic [31:0] pos;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done_seen = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [11:0] mk(bit enc, bit [1:0] src, bit [1:0] edg,
                                       bit [1:0] dir, bit [3:0] flt);
        return {flt, 1'b0, dir, edg, src, enc};
    endfunction

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(bit [1:0] d);
        ctl_wr = 1'b1;
        ctl_word = d;
        wait_n(1);
        ctl_wr = 1'b0;
        ctl_word = 2'b00;
    endtask

    task automatic set_in(int k, logic v);
        case (k)
            2: dig_in2 = v;
            3: dig_in3 = v;
            default: enc0_index = v;
        endcase
    endtask

    task automatic pulse(int k, int w, int settle);
        set_in(k, 1'b1);
        wait_n(w);
        set_in(k, 1'b0);
        wait_n(settle);
    endtask

    task automatic reconfig(logic [11:0] c);
        ctl(2'b10);
        cfg_word = c;
        wait_n(6);
    endtask

    task automatic expect_cap(logic [31:0] p, string tag);
        exp_t e;
        e.pos = p;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: each rising done flag is matched against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cap_done && !done_seen) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8: unexpected capture, actual %h expected none", cap_pos);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, cap_pos, e.pos);
                end
            end
            done_seen = cap_done;
        end
    end

    // Watchdog
    initial begin
        wait_n(60000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        wait_n(3);
        chk("R1 pos in reset", cap_pos, 32'h0);
        chk("R1 done in reset", {31'b0, cap_done}, 32'h0);
        rst = 1'b0;
        wait_n(2);
        chk("R1 done after reset", {31'b0, cap_done}, 32'h0);

        // R2/R3: strobe 2, rising, encoder 0
        enc0_pos = 32'h1111_0000;
        enc1_pos = 32'h2222_0000;
        reconfig(mk(0, 2'b10, 2'b00, 2'b11, 0));
        ctl(2'b01);
        chk("R7 done clear after arm", {31'b0, cap_done}, 32'h0);
        expect_cap(32'h1111_0000, "R2 R3 strobe2 enc0");
        pulse(2, 3, 10);
        chk("R7 done set", {31'b0, cap_done}, 32'h1);

        // R8: a second event while disarmed changes nothing
        enc0_pos = 32'h3333_3333;
        pulse(2, 3, 10);
        chk("R8 pos held", cap_pos, 32'h1111_0000);
        chk("R8 done held", {31'b0, cap_done}, 32'h1);

        // R2/R3/R4: strobe 3 falling edge, encoder 1, negative value
        reconfig(mk(1, 2'b01, 2'b01, 2'b11, 0));
        dig_in3 = 1'b1;
        wait_n(10);
        ctl(2'b01);
        chk("R7 done cleared by rearm", {31'b0, cap_done}, 32'h0);
        enc1_pos = 32'hFFFF_FF85;
        expect_cap(32'hFFFF_FF85, "R2 R4 strobe3 fall enc1");
        dig_in3 = 1'b0;
        wait_n(10);

        // R4: both edges
        reconfig(mk(0, 2'b10, 2'b10, 2'b11, 0));
        enc0_pos = 32'h0000_0100;
        ctl(2'b01);
        expect_cap(32'h0000_0100, "R4 both rise");
        dig_in2 = 1'b1;
        wait_n(10);
        enc0_pos = 32'h0000_0200;
        ctl(2'b01);
        expect_cap(32'h0000_0200, "R4 both fall");
        dig_in2 = 1'b0;
        wait_n(10);

        // R4: edge mode off
        reconfig(mk(0, 2'b10, 2'b11, 2'b11, 0));
        ctl(2'b01);
        pulse(2, 3, 10);
        chk("R4 off no capture", {31'b0, cap_done}, 32'h0);

        // R5: direction gating
        reconfig(mk(0, 2'b10, 2'b00, 2'b01, 0));
        enc0_fwd = 1'b1;
        ctl(2'b01);
        pulse(2, 3, 10);
        chk("R5 reverse-only blocks forward", {31'b0, cap_done}, 32'h0);
        enc0_fwd = 1'b0;
        enc0_pos = 32'h0000_7777;
        expect_cap(32'h0000_7777, "R5 reverse capture");
        pulse(2, 3, 10);
        reconfig(mk(1, 2'b10, 2'b00, 2'b10, 0));
        enc0_fwd = 1'b1;
        enc1_fwd = 1'b0;
        ctl(2'b01);
        pulse(2, 3, 10);
        chk("R5 uses selected encoder direction", {31'b0, cap_done}, 32'h0);
        enc1_fwd = 1'b1;
        enc1_pos = 32'h0000_8888;
        expect_cap(32'h0000_8888, "R5 forward capture enc1");
        pulse(2, 3, 10);
        reconfig(mk(0, 2'b10, 2'b00, 2'b00, 0));
        ctl(2'b01);
        pulse(2, 3, 10);
        chk("R5 dir none blocks", {31'b0, cap_done}, 32'h0);

        // R10: AND source with filtered strobe, unfiltered index
        reconfig(mk(0, 2'b00, 2'b00, 2'b11, 4'd2));
        enc0_pos = 32'h0000_000A;
        ctl(2'b01);
        dig_in2 = 1'b1;
        wait_n(40);
        chk("R10 strobe alone no capture", {31'b0, cap_done}, 32'h0);
        dig_in2 = 1'b0;
        wait_n(40);
        pulse(9, 1, 10);
        chk("R10 index alone no capture", {31'b0, cap_done}, 32'h0);
        dig_in2 = 1'b1;
        wait_n(40);
        expect_cap(32'h0000_000A, "R10 strobe AND index");
        pulse(9, 1, 10);
        dig_in2 = 1'b0;
        wait_n(40);

        // R3: index alone
        reconfig(mk(0, 2'b11, 2'b00, 2'b11, 0));
        enc0_pos = 32'h0000_000B;
        ctl(2'b01);
        expect_cap(32'h0000_000B, "R3 index source");
        pulse(9, 1, 10);

        // R6: filter windows
        reconfig(mk(0, 2'b10, 2'b00, 2'b11, 4'd1));
        enc0_pos = 32'h0000_0C01;
        ctl(2'b01);
        pulse(2, 8, 30);
        chk("R6 short pulse dropped N=1", {31'b0, cap_done}, 32'h0);
        expect_cap(32'h0000_0C01, "R6 long pulse N=1");
        pulse(2, 13, 30);
        reconfig(mk(0, 2'b10, 2'b00, 2'b11, 4'd15));
        enc0_pos = 32'h0000_0C0F;
        ctl(2'b01);
        pulse(2, 140, 200);
        chk("R6 short pulse dropped N=15", {31'b0, cap_done}, 32'h0);
        expect_cap(32'h0000_0C0F, "R6 long pulse N=15");
        pulse(2, 160, 200);
        reconfig(mk(0, 2'b10, 2'b00, 2'b11, 4'd0));
        enc0_pos = 32'h0000_0C00;
        ctl(2'b01);
        expect_cap(32'h0000_0C00, "R6 bypass one-cycle pulse");
        pulse(2, 1, 10);

        // R9: disarm cancels, and wins over a simultaneous arm
        held = 32'h0000_0C00;
        enc0_pos = 32'h0000_0D00;
        ctl(2'b01);
        ctl(2'b10);
        pulse(2, 3, 10);
        chk("R9 disarm cancels", {31'b0, cap_done}, 32'h0);
        ctl(2'b11);
        pulse(2, 3, 10);
        chk("R9 both bits from idle", {31'b0, cap_done}, 32'h0);
        ctl(2'b01);
        ctl(2'b11);
        pulse(2, 3, 10);
        chk("R9 both bits while armed", {31'b0, cap_done}, 32'h0);
        chk("R9 value untouched", cap_pos, held);

        chk("R8 all expected captures seen", exp_q.size(), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule